// File: doc/BRIEF.md
# Program Status and Exception Sequencer

This block keeps the processor's live status word and one saved copy of it for each of the five exception modes. Every clock it looks at six exception request lines, a return strobe, a branch-with-state-change strobe and a flag update from the ALU. When several of these arrive in the same cycle, it acts on the one with the highest rank. It then tells the fetch unit where to go next and tells the register file which return link to save.

An exception entry does four things. It copies the live status word into the saved slot of the target mode, switches to that mode and forces the 32-bit instruction state. It sets the interrupt masks and loads the vector address. A return copies the current mode's saved word back into the live word, which can bring back the 16-bit state. A branch with state change takes the new state from bit 0 of the target and leaves the mode unchanged. All outputs are registered, so every action shows at the ports one clock after the request.

Top module: `psr_exc_ctrl`

## Requirements
- R1: After reset the live word is: supervisor mode, both masks set, 32-bit state, all flags clear. `pc_load_o` and `link_we_o` are low.
- R2: Status word bit positions: flags N,Z,C,V at [31:28], interrupt mask at [7], fast-interrupt mask at [6], 16-bit state at [5], mode at [2:0]. Mode codes: user 0, fast interrupt 1, interrupt 2, supervisor 3, abort 4, undefined 5, system 6. All other bits read as zero.
- R3: A taken exception has the following effects one clock later:
  - the mode is the target mode;
  - `pc_next_o` holds the vector address;
  - `pc_load_o` and `link_we_o` pulse together;
  - `link_addr_o` equals `ret_addr_i`;
  - the target mode's saved word equals the previous live word.
- R4: Every entry clears the 16-bit state and sets the interrupt mask. A fast-interrupt entry also sets the fast-interrupt mask. The flags are kept.
- R5: Vector offsets from `VEC_BASE` and target modes:
  - data abort: 0x10, abort mode;
  - prefetch abort: 0x0C, abort mode;
  - fast interrupt: 0x1C, fast-interrupt mode;
  - interrupt: 0x18, interrupt mode;
  - undefined: 0x04, undefined mode;
  - software interrupt: 0x08, supervisor mode.
- R6: Request priority, highest first: data abort, prefetch abort, fast interrupt, interrupt, undefined, software interrupt. A fast interrupt is ignored while its mask is set, and an interrupt is ignored while its mask is set.
- R7: A return in an exception mode copies that mode's saved word into the live word and pulses `pc_load_o`. `pc_next_o` is `ret_target_i` with bit 0 cleared if the restored state is 16-bit, or with bits [1:0] cleared otherwise.
- R8: A return in user or system mode is ignored: there is no load pulse and the live word is unchanged.
- R9: A branch with state change sets the state bit to `bx_target_i[0]` and loads `pc_next_o` = target with bit 0 cleared. Mode and masks are unchanged.
- R10: Actions in one cycle rank as follows: an exception, then an effective return, then a branch with state change. A flag write updates the flags only in a cycle with no exception and no effective return, and it may combine with a branch.
- R11: In user or system mode the saved-word read returns zero and a saved-word write is ignored.
- R12: In an exception mode a saved-word write changes only that mode's saved copy. It is ignored in a cycle with an exception or an effective return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dabt_req_i | input | 1 | Data abort request |
| pabt_req_i | input | 1 | Prefetch abort request |
| fiq_req_i | input | 1 | Fast interrupt request |
| irq_req_i | input | 1 | Interrupt request |
| und_req_i | input | 1 | Undefined instruction request |
| swi_req_i | input | 1 | Software interrupt request |
| ret_addr_i | input | ADDR_W | Return address to save on entry |
| ret_strobe_i | input | 1 | Exception return request |
| ret_target_i | input | ADDR_W | Address to resume at on return |
| bx_strobe_i | input | 1 | Branch with state change |
| bx_target_i | input | ADDR_W | Branch target; bit 0 selects the state |
| flag_we_i | input | 1 | Flag update strobe |
| flag_i | input | 4 | New N,Z,C,V |
| spsr_we_i | input | 1 | Saved-word write for the current mode |
| spsr_wdata_i | input | 32 | Saved-word write data (R2 layout) |
| spsr_rdata_o | output | 32 | Saved word of the current mode (R2 layout) |
| mode_o | output | 3 | Current mode code |
| thumb_o | output | 1 | 1 = 16-bit state |
| flags_o | output | 4 | N,Z,C,V |
| irq_mask_o | output | 1 | Interrupt mask |
| fiq_mask_o | output | 1 | Fast-interrupt mask |
| pc_load_o | output | 1 | Load `pc_next_o` into the program counter |
| pc_next_o | output | ADDR_W | Next fetch address |
| link_we_o | output | 1 | Save return link in the current mode |
| link_addr_o | output | ADDR_W | Return link value to save |

## Verification
A wrong saved slot stays hidden until the program reads that mode's saved word or returns from that mode. At that point it shows up as wrong flags, masks, state or mode, one clock after the return strobe. A wrong arbitration or vector shows up one clock after the request, in `mode_o`, `pc_next_o` and the masks. The bench therefore sweeps every request combination under every mask setting and then returns from each entry, so that a corrupted saved copy appears at the ports within two cycles.

// File: rtl/psr_pkg.sv
// Shared types and helpers for the status/exception sequencer.
// Assumes mode codes fit in 3 bits; code 7 is unused.
package psr_pkg;

    localparam int NUM_BANKS = 5;
    localparam int NUM_EXC   = 6;

    typedef enum logic [2:0] {
        MODE_USR = 3'd0,
        MODE_FIQ = 3'd1,
        MODE_IRQ = 3'd2,
        MODE_SVC = 3'd3,
        MODE_ABT = 3'd4,
        MODE_UND = 3'd5,
        MODE_SYS = 3'd6
    } psr_mode_e;

    // Exception index doubles as priority rank (0 = highest)
    localparam int EXC_DABT = 0;
    localparam int EXC_PABT = 1;
    localparam int EXC_FIQ  = 2;
    localparam int EXC_IRQ  = 3;
    localparam int EXC_UND  = 4;
    localparam int EXC_SWI  = 5;

    typedef struct packed {
        logic [3:0] nzcv;
        logic       irq_off;
        logic       fiq_off;
        logic       thumb;
        logic [2:0] mode;
    } psr_t;

    function automatic logic [31:0] psr_pack(psr_t p);
        logic [31:0] w;
        w        = '0;
        w[31:28] = p.nzcv;
        w[7]     = p.irq_off;
        w[6]     = p.fiq_off;
        w[5]     = p.thumb;
        w[2:0]   = p.mode;
        return w;
    endfunction

    function automatic psr_t psr_unpack(logic [31:0] w);
        psr_t p;
        p.nzcv    = w[31:28];
        p.irq_off = w[7];
        p.fiq_off = w[6];
        p.thumb   = w[5];
        p.mode    = w[2:0];
        return p;
    endfunction

    // One-hot saved-slot select; zero for modes without a slot
    function automatic logic [NUM_BANKS-1:0] mode_bank_oh(logic [2:0] m);
        logic [NUM_BANKS-1:0] oh;
        case (m)
            MODE_FIQ: oh = 5'b00001;
            MODE_IRQ: oh = 5'b00010;
            MODE_SVC: oh = 5'b00100;
            MODE_ABT: oh = 5'b01000;
            MODE_UND: oh = 5'b10000;
            default:  oh = '0;
        endcase
        return oh;
    endfunction

    function automatic logic [7:0] exc_offset(logic [2:0] idx);
        logic [7:0] off;
        case (idx)
            3'd0:    off = 8'h10;
            3'd1:    off = 8'h0C;
            3'd2:    off = 8'h1C;
            3'd3:    off = 8'h18;
            3'd4:    off = 8'h04;
            default: off = 8'h08;
        endcase
        return off;
    endfunction

    function automatic logic [2:0] exc_mode(logic [2:0] idx);
        logic [2:0] m;
        case (idx)
            3'd0, 3'd1: m = MODE_ABT;
            3'd2:       m = MODE_FIQ;
            3'd3:       m = MODE_IRQ;
            3'd4:       m = MODE_UND;
            default:    m = MODE_SVC;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/psr_exc_arbiter.sv
// Picks the highest-ranked unmasked exception request and derives its
// target mode and vector address. Purely combinational.
// Assumes VEC_BASE is word aligned.
module psr_exc_arbiter
    import psr_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic [NUM_EXC-1:0] req_i,
    input  logic               irq_off_i,
    input  logic               fiq_off_i,
    output logic               take_o,
    output logic               fiq_sel_o,
    output logic [2:0]         mode_o,
    output logic [ADDR_W-1:0]  vector_o
);

    logic [NUM_EXC-1:0] eff;
    logic [2:0]         sel;

    // Gate the maskable requests
    always_comb begin
        eff          = req_i;
        eff[EXC_FIQ] = req_i[EXC_FIQ] & ~fiq_off_i;
        eff[EXC_IRQ] = req_i[EXC_IRQ] & ~irq_off_i;
    end

    // Fixed priority: the lowest index present wins
    always_comb begin
        take_o = 1'b0;
        sel    = 3'd0;
        for (int i = NUM_EXC - 1; i >= 0; i--) begin
            if (eff[i]) begin
                take_o = 1'b1;
                sel    = 3'(i);
            end
        end
    end

    // Decode the winner
    always_comb begin
        fiq_sel_o = take_o && (sel == 3'(EXC_FIQ));
        mode_o    = exc_mode(sel);
        vector_o  = VEC_BASE + ADDR_W'(exc_offset(sel));
    end

endmodule

// File: rtl/psr_bank.sv
// Saved status words, one per exception mode. Entry saves have priority
// over software writes; the read port follows the current mode and
// returns zero when that mode has no slot.
// Assumes the caller suppresses writes in entry and return cycles.
module psr_bank
    import psr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cur_mode_i,
    input  logic       wr_en_i,
    input  psr_t       wr_word_i,
    input  logic       save_en_i,
    input  logic [2:0] save_mode_i,
    input  psr_t       save_word_i,
    output psr_t       rd_word_o,
    output logic       rd_valid_o
);

    logic [NUM_BANKS-1:0] cur_oh;
    logic [NUM_BANKS-1:0] save_oh;
    psr_t                 slot_q [NUM_BANKS];

    // Slot selects for the current and the target mode
    always_comb begin
        cur_oh  = mode_bank_oh(cur_mode_i);
        save_oh = mode_bank_oh(save_mode_i);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
        // Hold one saved word; entry save beats a software write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[b] <= '0;
            end else if (save_en_i && save_oh[b]) begin
                slot_q[b] <= save_word_i;
            end else if (wr_en_i && cur_oh[b]) begin
                slot_q[b] <= wr_word_i;
            end
        end
    end

    // Read mux for the current mode's slot
    always_comb begin
        rd_word_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (cur_oh[b]) rd_word_o = rd_word_o | slot_q[b];
        end
        rd_valid_o = |cur_oh;
    end

endmodule

// File: rtl/psr_exc_ctrl.sv
// Status word and exception sequencer top. Ranks exception entry,
// return, state-changing branch and flag update each cycle, updates the
// live status word and emits a registered next-PC and link request.
// Assumes the core holds a request only as long as it needs service.
module psr_exc_ctrl
    import psr_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dabt_req_i,
    input  logic              pabt_req_i,
    input  logic              fiq_req_i,
    input  logic              irq_req_i,
    input  logic              und_req_i,
    input  logic              swi_req_i,
    input  logic [ADDR_W-1:0] ret_addr_i,
    input  logic              ret_strobe_i,
    input  logic [ADDR_W-1:0] ret_target_i,
    input  logic              bx_strobe_i,
    input  logic [ADDR_W-1:0] bx_target_i,
    input  logic              flag_we_i,
    input  logic [3:0]        flag_i,
    input  logic              spsr_we_i,
    input  logic [31:0]       spsr_wdata_i,
    output logic [31:0]       spsr_rdata_o,
    output logic [2:0]        mode_o,
    output logic              thumb_o,
    output logic [3:0]        flags_o,
    output logic              irq_mask_o,
    output logic              fiq_mask_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_next_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_addr_o
);

    localparam psr_t RESET_PSR = '{nzcv: 4'h0, irq_off: 1'b1, fiq_off: 1'b1,
                                   thumb: 1'b0, mode: MODE_SVC};

    psr_t               cpsr_q, cpsr_d;
    logic [NUM_EXC-1:0] req;
    logic               take, fiq_sel;
    logic [2:0]         tgt_mode;
    logic [ADDR_W-1:0]  vector;
    psr_t               saved_word;
    logic               saved_valid;
    logic               ret_ok, bx_ok, flag_ok, wr_ok;
    logic [ADDR_W-1:0]  pc_d;
    logic               pc_load_d;
    logic [ADDR_W-1:0]  pc_q, link_q;
    logic               pc_load_q, link_we_q;

    // Collect requests in rank order
    always_comb begin
        req           = '0;
        req[EXC_DABT] = dabt_req_i;
        req[EXC_PABT] = pabt_req_i;
        req[EXC_FIQ]  = fiq_req_i;
        req[EXC_IRQ]  = irq_req_i;
        req[EXC_UND]  = und_req_i;
        req[EXC_SWI]  = swi_req_i;
    end

    psr_exc_arbiter #(
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) arb_i (
        .req_i     (req),
        .irq_off_i (cpsr_q.irq_off),
        .fiq_off_i (cpsr_q.fiq_off),
        .take_o    (take),
        .fiq_sel_o (fiq_sel),
        .mode_o    (tgt_mode),
        .vector_o  (vector)
    );

    psr_bank bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_mode_i  (cpsr_q.mode),
        .wr_en_i     (wr_ok),
        .wr_word_i   (psr_unpack(spsr_wdata_i)),
        .save_en_i   (take),
        .save_mode_i (tgt_mode),
        .save_word_i (cpsr_q),
        .rd_word_o   (saved_word),
        .rd_valid_o  (saved_valid)
    );

    // Rank the competing actions of this cycle
    always_comb begin
        ret_ok  = ret_strobe_i && !take && saved_valid;
        bx_ok   = bx_strobe_i && !take && !ret_ok;
        flag_ok = flag_we_i && !take && !ret_ok;
        wr_ok   = spsr_we_i && !take && !ret_ok;
    end

    // Next live status word
    always_comb begin
        cpsr_d = cpsr_q;
        if (take) begin
            cpsr_d.irq_off = 1'b1;
            cpsr_d.fiq_off = cpsr_q.fiq_off | fiq_sel;
            cpsr_d.thumb   = 1'b0;
            cpsr_d.mode    = tgt_mode;
        end else if (ret_ok) begin
            cpsr_d = saved_word;
        end else begin
            if (bx_ok)   cpsr_d.thumb = bx_target_i[0];
            if (flag_ok) cpsr_d.nzcv  = flag_i;
        end
    end

    // Next fetch address and its load strobe
    always_comb begin
        pc_load_d = take || ret_ok || bx_ok;
        pc_d      = pc_q;
        if (take) begin
            pc_d = vector;
        end else if (ret_ok) begin
            pc_d = saved_word.thumb ? {ret_target_i[ADDR_W-1:1], 1'b0}
                                    : {ret_target_i[ADDR_W-1:2], 2'b00};
        end else if (bx_ok) begin
            pc_d = {bx_target_i[ADDR_W-1:1], 1'b0};
        end
    end

    // Live status word register
    always_ff @(posedge clk) begin
        if (!rst_n) cpsr_q <= RESET_PSR;
        else        cpsr_q <= cpsr_d;
    end

    // Fetch redirect and link request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            pc_load_q <= 1'b0;
            link_we_q <= 1'b0;
            link_q    <= '0;
        end else begin
            pc_q      <= pc_d;
            pc_load_q <= pc_load_d;
            link_we_q <= take;
            if (take) link_q <= ret_addr_i;
        end
    end

    // Drive the ports from the registers
    always_comb begin
        mode_o       = cpsr_q.mode;
        thumb_o      = cpsr_q.thumb;
        flags_o      = cpsr_q.nzcv;
        irq_mask_o   = cpsr_q.irq_off;
        fiq_mask_o   = cpsr_q.fiq_off;
        pc_load_o    = pc_load_q;
        pc_next_o    = pc_q;
        link_we_o    = link_we_q;
        link_addr_o  = link_q;
        spsr_rdata_o = psr_pack(saved_word);
    end

endmodule

// File: rtl/psr_exc_ctrl_chk.sv
// Port-level property checker for psr_exc_ctrl, attached by bind.
// Assumes the mode codes and vector offsets given in the package.
module psr_exc_ctrl_chk #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dabt_req_i,
    input logic              pabt_req_i,
    input logic              fiq_req_i,
    input logic              irq_req_i,
    input logic              und_req_i,
    input logic              swi_req_i,
    input logic              ret_strobe_i,
    input logic              bx_strobe_i,
    input logic [ADDR_W-1:0] bx_target_i,
    input logic [31:0]       spsr_rdata_o,
    input logic [2:0]        mode_o,
    input logic              thumb_o,
    input logic              irq_mask_o,
    input logic              fiq_mask_o,
    input logic              pc_load_o,
    input logic [ADDR_W-1:0] pc_next_o,
    input logic              link_we_o
);

    logic any_req;
    always_comb any_req = dabt_req_i | pabt_req_i | fiq_req_i | irq_req_i | und_req_i | swi_req_i;

    AST_DABT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        dabt_req_i |=> (mode_o == 3'd4 && link_we_o && pc_next_o == VEC_BASE + ADDR_W'(8'h10))); // R6

    AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (!thumb_o && irq_mask_o)); // R4

    AST_FIQ_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we_o && mode_o == 3'd1) |-> fiq_mask_o); // R4

    AST_LINK_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> pc_load_o); // R3

    AST_BX_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_strobe_i && !ret_strobe_i && !any_req) |=>
        (pc_load_o && mode_o == $past(mode_o) && thumb_o == $past(bx_target_i[0]))); // R9

    AST_LOAD_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> !pc_next_o[0]); // R7

    AST_NOSLOT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 || mode_o == 3'd6) |-> spsr_rdata_o == 32'h0); // R11

    AST_NOSLOT_RETURN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe_i && !bx_strobe_i && !any_req && (mode_o == 3'd0 || mode_o == 3'd6)) |=>
        (!pc_load_o && $stable(mode_o))); // R8

endmodule

bind psr_exc_ctrl psr_exc_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dabt_req_i   (dabt_req_i),
    .pabt_req_i   (pabt_req_i),
    .fiq_req_i    (fiq_req_i),
    .irq_req_i    (irq_req_i),
    .und_req_i    (und_req_i),
    .swi_req_i    (swi_req_i),
    .ret_strobe_i (ret_strobe_i),
    .bx_strobe_i  (bx_strobe_i),
    .bx_target_i  (bx_target_i),
    .spsr_rdata_o (spsr_rdata_o),
    .mode_o       (mode_o),
    .thumb_o      (thumb_o),
    .irq_mask_o   (irq_mask_o),
    .fiq_mask_o   (fiq_mask_o),
    .pc_load_o    (pc_load_o),
    .pc_next_o    (pc_next_o),
    .link_we_o    (link_we_o)
);

// File: tb/psr_exc_ctrl_tb_top.sv
// Self-checking bench: directed cases plus a sweep of all request
// combinations under all mask settings, each followed by a return.
module psr_exc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dabt, pabt, fiq, irq, und, swi;
    logic [31:0] ret_addr, ret_target, bx_target, spsr_wdata;
    logic        ret_strobe, bx_strobe, flag_we, spsr_we;
    logic [3:0]  flag_in;
    logic [31:0] spsr_rdata, pc_next, link_addr;
    logic [2:0]  mode;
    logic        thumb, irq_mask, fiq_mask, pc_load, link_we;
    logic [3:0]  flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    psr_exc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .dabt_req_i(dabt), .pabt_req_i(pabt), .fiq_req_i(fiq),
        .irq_req_i(irq), .und_req_i(und), .swi_req_i(swi),
        .ret_addr_i(ret_addr), .ret_strobe_i(ret_strobe), .ret_target_i(ret_target),
        .bx_strobe_i(bx_strobe), .bx_target_i(bx_target),
        .flag_we_i(flag_we), .flag_i(flag_in),
        .spsr_we_i(spsr_we), .spsr_wdata_i(spsr_wdata), .spsr_rdata_o(spsr_rdata),
        .mode_o(mode), .thumb_o(thumb), .flags_o(flags),
        .irq_mask_o(irq_mask), .fiq_mask_o(fiq_mask),
        .pc_load_o(pc_load), .pc_next_o(pc_next),
        .link_we_o(link_we), .link_addr_o(link_addr)
    );

    // Live word rebuilt from the ports in the R2 layout
    function automatic logic [31:0] live();
        return {flags, 20'h0, irq_mask, fiq_mask, thumb, 2'b00, mode};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        {dabt, pabt, fiq, irq, und, swi} = '0;
        ret_strobe = 0; bx_strobe = 0; flag_we = 0; spsr_we = 0;
        ret_addr = '0; ret_target = '0; bx_target = '0; spsr_wdata = '0; flag_in = '0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // From supervisor mode: write its saved word then return into it
    task automatic load_state(logic [31:0] w);
        spsr_we = 1; spsr_wdata = w; tick(); spsr_we = 0;
        ret_strobe = 1; ret_target = '0; tick(); ret_strobe = 0;
    endtask

    // Bench-side rank of request bits {swi,und,irq,fiq,pabt,dabt}
    function automatic int pick(logic [5:0] r, bit ioff, bit foff);
        logic [5:0] e;
        e = r; e[2] = r[2] & ~foff; e[3] = r[3] & ~ioff;
        for (int i = 0; i < 6; i++) if (e[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] vec_of(int k);
        case (k)
            0: return 32'h10; 1: return 32'h0C; 2: return 32'h1C;
            3: return 32'h18; 4: return 32'h04; default: return 32'h08;
        endcase
    endfunction

    function automatic logic [2:0] mode_of(int k);
        case (k)
            0, 1: return 3'd4; 2: return 3'd1; 3: return 3'd2;
            4: return 3'd5; default: return 3'd3;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick();
        do_reset();
        // R1: reset state
        chk("R1 live word", live(), 32'h0000_00C3);
        chk("R1 pc_load", {31'h0, pc_load}, 32'h0);
        chk("R1 link_we", {31'h0, link_we}, 32'h0);

        // R2: write layout, undefined bits drop
        spsr_we = 1; spsr_wdata = 32'h5ABC_DE6B; tick(); spsr_we = 0;
        chk("R2 saved readback", spsr_rdata, 32'h5000_0063);
        chk("R12 write leaves live word", live(), 32'h0000_00C3);
        // R7: return restores 16-bit state, clears bit 0 only
        ret_strobe = 1; ret_target = 32'h0000_0107; tick(); ret_strobe = 0;
        chk("R7 restored word", live(), 32'h5000_0063);
        chk("R7 pc_next", pc_next, 32'h0000_0106);
        chk("R7 pc_load", {31'h0, pc_load}, 32'h1);
        // R9: branch to 32-bit state
        bx_strobe = 1; bx_target = 32'h0000_4002; tick(); bx_strobe = 0;
        chk("R9 to 32-bit", live(), 32'h5000_0043);
        chk("R9 pc_next", pc_next, 32'h0000_4002);
        // R9 + R10: branch to 16-bit with flag update
        bx_strobe = 1; bx_target = 32'h0000_3001; flag_we = 1; flag_in = 4'hC; tick();
        bx_strobe = 0; flag_we = 0;
        chk("R10 branch with flags", live(), 32'hC000_0063);
        chk("R9 pc_next odd", pc_next, 32'h0000_3000);
        // R10: flag write alone
        flag_we = 1; flag_in = 4'h1; tick(); flag_we = 0;
        chk("R10 flags alone", live(), 32'h1000_0063);
        chk("R10 no load", {31'h0, pc_load}, 32'h0);

        // R12: chain through saved words by returns only
        do_reset();
        load_state(32'h0000_00C4);
        chk("R7 to abort mode", live(), 32'h0000_00C4);
        chk("R12 abort slot untouched", spsr_rdata, 32'h0);
        spsr_we = 1; spsr_wdata = 32'h8000_0025; tick(); spsr_we = 0;
        chk("R12 abort slot write", spsr_rdata, 32'h8000_0025);
        ret_strobe = 1; ret_target = 32'h0000_0203; tick(); ret_strobe = 0;
        chk("R7 to undefined mode", live(), 32'h8000_0025);
        chk("R12 undefined slot untouched", spsr_rdata, 32'h0);
        spsr_we = 1; spsr_wdata = 32'h1000_0000; tick(); spsr_we = 0;
        ret_strobe = 1; tick(); ret_strobe = 0;
        chk("R7 to user mode", live(), 32'h1000_0000);
        // R11: no slot in user mode
        chk("R11 user read zero", spsr_rdata, 32'h0);
        spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; tick(); spsr_we = 0;
        chk("R11 user write ignored", spsr_rdata, 32'h0);
        chk("R11 live unchanged", live(), 32'h1000_0000);
        // R8: return in user mode ignored
        ret_strobe = 1; ret_target = 32'h0000_0700; tick(); ret_strobe = 0;
        chk("R8 user return no load", {31'h0, pc_load}, 32'h0);
        chk("R8 user return live", live(), 32'h1000_0000);
        // R3: software interrupt saves the user word
        swi = 1; ret_addr = 32'h0000_0ABC; tick(); swi = 0;
        chk("R3 swi live", live(), 32'h1000_0083);
        chk("R3 swi saved", spsr_rdata, 32'h1000_0000);
        chk("R5 swi vector", pc_next, 32'h0000_0008);
        chk("R3 link addr", link_addr, 32'h0000_0ABC);

        // R8/R11: system mode
        do_reset();
        load_state(32'h0000_0006);
        chk("R11 system read zero", spsr_rdata, 32'h0);
        ret_strobe = 1; tick(); ret_strobe = 0;
        chk("R8 system return ignored", live(), 32'h0000_0006);

        // R3..R7, R10: every request mix under every mask setting
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 64; r++) begin
                logic [31:0] w, exp_w;
                int k;
                bit t;
                t = r[0];
                w = {4'hA, 20'h0, m[1], m[0], t, 2'b00, 3'd0};
                do_reset();
                load_state(w);
                {swi, und, irq, fiq, pabt, dabt} = 6'(r);
                ret_addr = 32'h1000_0000 + 32'(r * 16);
                flag_we = 1; flag_in = 4'h3;
                tick();
                idle();
                k = pick(6'(r), m[1], m[0]);
                if (k >= 0) begin
                    exp_w = {4'hA, 20'h0, 1'b1, m[0] | (k == 2), 1'b0, 2'b00, mode_of(k)};
                    chk("R4 R6 entry live word", live(), exp_w);
                    chk("R5 vector", pc_next, vec_of(k));
                    chk("R3 load and link", {30'h0, pc_load, link_we}, 32'h3);
                    chk("R3 link addr", link_addr, 32'h1000_0000 + 32'(r * 16));
                    chk("R3 saved word", spsr_rdata, w);
                    ret_strobe = 1; ret_target = 32'h0000_2003; tick(); ret_strobe = 0;
                    chk("R7 restore", live(), w);
                    chk("R7 return pc", pc_next, t ? 32'h0000_2002 : 32'h0000_2000);
                    chk("R3 link pulse ends", {30'h0, pc_load, link_we}, 32'h2);
                end else begin
                    exp_w = {4'h3, w[27:0]};
                    chk("R6 masked no entry", live(), exp_w);
                    chk("R10 no load", {30'h0, pc_load, link_we}, 32'h0);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule